// File: doc/BRIEF.md
# Instruction count debug trigger

This block is one trigger slot of a processor's debug trigger bank, configured as an instruction counter. Software loads the slot's first data register (the control word) through a write port. The control word holds the trigger type, a 14-bit remaining count and a set of privilege enables. Each time the core retires an instruction, the slot checks whether the current privilege level is enabled. If it is, and the slot is active, the count drops by one. When the count steps from one to zero, the slot raises a one-cycle breakpoint request, and the core turns that request into a breakpoint exception.

The remaining count is stored inside the control word itself. A read therefore always shows how many instructions are left. A count of zero, or a type other than instruction count, leaves the slot inert. The retire strobe, privilege level and virtualisation flag are plain control inputs sampled every cycle; none of the ports carries a data stream, so there is no back-pressure.

Control word layout (XLEN = 32):

| Bits | Field |
| --- | --- |
| 31:28 | type |
| 26 | VS enable |
| 25 | VU enable |
| 23:10 | count |
| 9 | M enable |
| 7 | S enable |
| 6 | U enable |

Privilege encoding on `priv`: 0 = U, 1 = S, 2 = reserved, 3 = M.

Top module: `icnt_trigger`

## Requirements
- R1: After reset the control word reads as all zero and `bp_req` is low.
- R2: A write stores only the fields in the layout above (type 31:28, VS 26, VU 25, count 23:10, M 9, S 7, U 6); every other bit reads as zero. This covers the mode bit 27, hit bit 24, pending bit 8 and action bits 5:0.
- R3: On a cycle with `retire` high, no write, type equal to 3 (instruction count), a non-zero count and the current privilege enabled, the count reads one lower from the next cycle on.
- R4: A retire in a privilege level whose enable bit is clear leaves the control word unchanged.
- R5: With `virt` low, priv 0, 1 and 3 are enabled by bits 6, 7 and 9 respectively. With `virt` high, priv 0 is enabled by bit 25 and priv 1 by bit 26. Priv 2, and priv 3 while `virt` is high, are never enabled.
- R6: A count of zero is inert: retires change nothing and raise no request.
- R7: A type field other than 3 makes the slot inert, whatever the count and enables.
- R8: A decrement from 1 to 0 raises `bp_req` for exactly one cycle. That cycle is the first one in which the count reads zero.
- R9: A write in the same cycle as a retire stores the written (filtered) value, skips the decrement and raises no request.
- R10: A read returns the count with every earlier decrement already applied, so after N counted retires the count equals the loaded value minus N.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire | input | 1 | One instruction retired this cycle |
| priv | input | 2 | Current privilege level (0 U, 1 S, 3 M) |
| virt | input | 1 | Virtualisation mode active |
| cfg_wr | input | 1 | Software write strobe for the control word |
| cfg_wdata | input | XLEN | Value written to the control word |
| cfg_rdata | output | XLEN | Current control word, including the live count |
| bp_req | output | 1 | Breakpoint request, one-cycle pulse |

## Verification
The hardest case to reach from the ports is a retire that lands in the same cycle as a software write while the count stands at one. Here the write must win, and the request must stay quiet even though a decrement would otherwise fire it. Directed sequences load a count of one and then issue a write and a retire together. The random phase loads small counts (0 to 4) most of the time with type 3, so that both this collision and the natural one-to-zero step occur many times under mixed privilege and virtualisation values.

// File: rtl/icnt_pkg.sv
package icnt_pkg;
  localparam int unsigned TYPE_W  = 4;
  localparam logic [TYPE_W-1:0] TYPE_ICOUNT = 4'd3;
  localparam int unsigned CNT_W   = 14;
  localparam int unsigned CNT_LSB = 10;
  localparam int unsigned EN_U    = 6;
  localparam int unsigned EN_S    = 7;
  localparam int unsigned EN_M    = 9;
  localparam int unsigned EN_VU   = 25;
  localparam int unsigned EN_VS   = 26;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;
endpackage

// File: rtl/icnt_cfg_filter.sv
module icnt_cfg_filter
  import icnt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] kept
);
  localparam int unsigned TYPE_LSB = XLEN - TYPE_W;

  always_comb begin
    kept = '0;
    kept[TYPE_LSB +: TYPE_W] = raw[TYPE_LSB +: TYPE_W];
    kept[CNT_LSB +: CNT_W]   = raw[CNT_LSB +: CNT_W];
    kept[EN_VS] = raw[EN_VS];
    kept[EN_VU] = raw[EN_VU];
    kept[EN_M]  = raw[EN_M];
    kept[EN_S]  = raw[EN_S];
    kept[EN_U]  = raw[EN_U];
  end
endmodule

// File: rtl/icnt_priv_match.sv
module icnt_priv_match
  import icnt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] ctrl,
  input  logic [1:0]      priv,
  input  logic            virt,
  output logic            en
);
  priv_e lvl;

  always_comb begin
    lvl = priv_e'(priv);
    en  = 1'b0;
    if (virt) begin
      case (lvl)
        PRIV_U:  en = ctrl[EN_VU];
        PRIV_S:  en = ctrl[EN_VS];
        default: en = 1'b0;
      endcase
    end else begin
      case (lvl)
        PRIV_U:  en = ctrl[EN_U];
        PRIV_S:  en = ctrl[EN_S];
        PRIV_M:  en = ctrl[EN_M];
        default: en = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/icnt_counter.sv
module icnt_counter
  import icnt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [XLEN-1:0] ld_val,
  input  logic            retire,
  input  logic            en,
  output logic [XLEN-1:0] ctrl_q,
  output logic            bp_q
);
  localparam int unsigned TYPE_LSB = XLEN - TYPE_W;

  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             step;
  logic             last;

  assign cnt    = ctrl_q[CNT_LSB +: CNT_W];
  assign active = (ctrl_q[TYPE_LSB +: TYPE_W] == TYPE_ICOUNT) && (cnt != '0);
  assign step   = retire && en && active && !ld;
  assign last   = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      bp_q   <= 1'b0;
    end else begin
      bp_q <= step && last;
      if (ld) begin
        ctrl_q <= ld_val;
      end else if (step) begin
        ctrl_q[CNT_LSB +: CNT_W] <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/icnt_trigger.sv
module icnt_trigger
  import icnt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic            cfg_wr,
  input  logic [XLEN-1:0] cfg_wdata,
  output logic [XLEN-1:0] cfg_rdata,
  output logic            bp_req
);
  logic [XLEN-1:0] wr_kept;
  logic [XLEN-1:0] ctrl;
  logic            priv_en;

  icnt_cfg_filter #(.XLEN(XLEN)) u_filter (
    .raw  (cfg_wdata),
    .kept (wr_kept)
  );

  icnt_priv_match #(.XLEN(XLEN)) u_match (
    .ctrl (ctrl),
    .priv (priv),
    .virt (virt),
    .en   (priv_en)
  );

  icnt_counter #(.XLEN(XLEN)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (cfg_wr),
    .ld_val (wr_kept),
    .retire (retire),
    .en     (priv_en),
    .ctrl_q (ctrl),
    .bp_q   (bp_req)
  );

  assign cfg_rdata = ctrl;
endmodule

// File: rtl/icnt_trigger_chk.sv
module icnt_trigger_chk
  import icnt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            retire,
  input logic            cfg_wr,
  input logic [XLEN-1:0] cfg_rdata,
  input logic            bp_req
);
  logic [XLEN-1:0] free_bits;
  always_comb begin
    free_bits = '1;
    free_bits[XLEN-1 -: TYPE_W] = '0;
    free_bits[CNT_LSB +: CNT_W] = '0;
    free_bits[EN_VS] = 1'b0;
    free_bits[EN_VU] = 1'b0;
    free_bits[EN_M]  = 1'b0;
    free_bits[EN_S]  = 1'b0;
    free_bits[EN_U]  = 1'b0;
  end

  AST_UNKEPT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & free_bits) == '0); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !retire) |=> $stable(cfg_rdata)); // R4

  AST_ZERO_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && cfg_rdata[CNT_LSB +: CNT_W] == '0) |=> ($stable(cfg_rdata) && !bp_req)); // R6

  AST_BP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |-> (cfg_rdata[CNT_LSB +: CNT_W] == '0)); // R8

  AST_BP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |=> !bp_req); // R8

  AST_WRITE_NO_BP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !bp_req); // R9
endmodule

bind icnt_trigger icnt_trigger_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .retire    (retire),
  .cfg_wr    (cfg_wr),
  .cfg_rdata (cfg_rdata),
  .bp_req    (bp_req)
);

// File: tb/sim_icnt_trigger.sv
`timescale 1ns/1ps
module sim_icnt_trigger;
  localparam int XLEN = 32;
  localparam logic [31:0] KEEP = 32'hF6FF_FEC0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire = 1'b0;
  logic [1:0] priv = 2'd3;
  logic virt = 1'b0;
  logic cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic bp_req;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_reg = '0;
  logic m_bp = 1'b0;

  always #10 clk = ~clk;

  icnt_trigger #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .retire(retire), .priv(priv), .virt(virt),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bp_req(bp_req)
  );

  function automatic logic priv_on(logic [31:0] c, logic [1:0] p, logic v);
    if (v) return (p == 2'd0) ? c[25] : (p == 2'd1) ? c[26] : 1'b0;
    case (p)
      2'd0: return c[6];
      2'd1: return c[7];
      2'd3: return c[9];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] mk(logic [3:0] t, logic [13:0] n, logic [31:0] en);
    return ({t, 28'h0} | {8'h0, n, 10'h0} | en);
  endfunction

  task automatic chk(string req);
    checks++;
    if (cfg_rdata !== m_reg || bp_req !== m_bp) begin
      errors++;
      $display("FAIL %s: rdata=%h bp=%b expected rdata=%h bp=%b", req, cfg_rdata, bp_req, m_reg, m_bp);
    end
  endtask

  // drive one cycle from a negedge, advance the model, check at the next negedge
  task automatic cyc(logic wr, logic [31:0] wd, logic ret, logic [1:0] p, logic v, string req);
    logic [13:0] n;
    cfg_wr = wr; cfg_wdata = wd; retire = ret; priv = p; virt = v;
    n = m_reg[23:10];
    if (wr) begin
      m_reg = wd & KEEP; m_bp = 1'b0;
    end else if (ret && m_reg[31:28] == 4'd3 && n != 0 && priv_on(m_reg, p, v)) begin
      m_reg[23:10] = n - 14'd1; m_bp = (n == 14'd1);
    end else begin
      m_bp = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0; retire = 1'b0;
    chk(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: rdata=%h expected completion", cfg_rdata);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1");
    cyc(1, 32'hFFFF_FFFF, 0, 3, 0, "R2");
    cyc(1, 32'h0800_0000 | 32'h0100_0100 | 32'h3F, 0, 3, 0, "R2");
    // count of three in M mode
    cyc(1, mk(3, 3, 32'h200), 0, 3, 0, "R3");
    cyc(0, 0, 1, 3, 0, "R3");
    cyc(0, 0, 0, 3, 0, "R10");
    cyc(0, 0, 1, 3, 0, "R10");
    cyc(0, 0, 1, 3, 0, "R8");
    if (bp_req !== 1'b1) begin errors++; $display("FAIL R8: bp=%b expected 1", bp_req); end
    checks++;
    cyc(0, 0, 1, 3, 0, "R8");
    cyc(0, 0, 1, 3, 0, "R6");
    // disabled levels
    cyc(1, mk(3, 5, 32'h200), 0, 3, 0, "R4");
    cyc(0, 0, 1, 0, 0, "R4");
    cyc(0, 0, 1, 1, 0, "R4");
    cyc(0, 0, 1, 2, 0, "R5");
    // virtual mapping
    cyc(1, mk(3, 5, 32'h0200_0000), 0, 0, 0, "R5");
    cyc(0, 0, 1, 0, 0, "R5");
    cyc(0, 0, 1, 0, 1, "R5");
    cyc(0, 0, 1, 1, 1, "R5");
    cyc(0, 0, 1, 3, 1, "R5");
    cyc(1, mk(3, 5, 32'h0400_0000 | 32'h200), 0, 0, 0, "R5");
    cyc(0, 0, 1, 1, 1, "R5");
    cyc(0, 0, 1, 3, 1, "R5");
    cyc(0, 0, 1, 3, 0, "R5");
    // wrong type
    cyc(1, mk(2, 4, 32'h2C0), 0, 3, 0, "R7");
    cyc(0, 0, 1, 3, 0, "R7");
    cyc(0, 0, 1, 0, 0, "R7");
    // write collides with retire at count one
    cyc(1, mk(3, 1, 32'h200), 0, 3, 0, "R9");
    cyc(1, mk(3, 1, 32'h200), 1, 3, 0, "R9");
    cyc(1, mk(3, 7, 32'h200), 1, 3, 0, "R9");
    cyc(0, 0, 1, 3, 0, "R3");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] wd;
      logic wr;
      wd = $urandom;
      wd[31:28] = ($urandom % 4 != 0) ? 4'd3 : 4'($urandom);
      wd[23:10] = 14'($urandom % 5);
      wr = ($urandom % 8) == 0;
      cyc(wr, wd, ($urandom % 5) < 3, 2'($urandom), ($urandom % 4) == 0, "R3");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule